// File: doc/BRIEF.md
# Sector Hamming Check-and-Repair Unit

This unit closes the read path of a NAND sector guarded by a 24-bit Hamming code over 512 data bytes. After a sector has been streamed into the attached sector memory, the controller presents two 3-byte codes: the one recovered from the spare area and the one produced by the parity generator while the data went past. A `start` pulse launches one evaluation. The unit spreads each packed code into a 32-bit word, XORs the two words and counts the set bits of the difference. From that count it reports one of four verdicts: clean, corrected, code corrupted, or uncorrectable.

When the difference has the shape of a single flipped data bit, the unit derives the byte and bit position from the upper half of the difference. It then repairs the sector memory itself with a read-modify-write of that byte before it signals completion. A freshly erased page reads back as all-ones in the spare area against an all-zero computed code, and that combination is accepted as clean. The sector memory has a host port, with writes and one-cycle-latency reads, that fills the sector before a check and drains it afterwards.

Top module: `sector_ecc_fixer`

## Requirements
- R1: A packed code is 24 bits with byte0 in [7:0], byte1 in [15:8] and byte2 in [23:16]. It is spread to 32 bits as byte0 into [7:0], the low nibble of byte2 into [11:8], byte1 into [23:16] and the high nibble of byte2 into [27:24], with all other bits zero. If the two spread words are equal, the verdict is clean (status 0).
- R2: A difference with exactly 12 set bits gives status 1 (corrected). `err_byte` is then difference bits [27:19] and `err_bit` is difference bits [18:16].
- R3: On status 1, the sector memory byte at `err_byte` has bit `err_bit` inverted, and every other byte keeps its value.
- R4: A difference with exactly one set bit gives status 2 (code corrupted), and the sector memory is left unchanged.
- R5: A stored code that spreads to 0x0FFF0FFF (packed 0xFFFFFF) together with a computed code of zero gives status 0.
- R6: Every other non-zero difference gives status 3 (uncorrectable), and the sector memory is left unchanged.
- R7: `start` seen while idle raises `busy` at the next edge. `done` is a single-cycle pulse, registered one edge after that for statuses 0, 2 and 3 and three edges after it for status 1. `busy` falls at the edge that raises `done`.
- R8: `start` seen while `busy` is high is ignored.
- R9: A host write takes effect only while the unit is idle, and a host read returns the addressed byte one cycle after the address is presented.
- R10: After reset, `busy`, `done`, `status`, `err_byte` and `err_bit` are all zero.
- R11: For any verdict other than corrected, `err_byte` and `err_bit` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one evaluation (honoured while idle) |
| stored_code | input | 24 | Packed code read from the spare area |
| calc_code | input | 24 | Packed code computed over the sector data |
| busy | output | 1 | Evaluation or repair in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 code corrupted, 3 uncorrectable |
| err_byte | output | 9 | Byte position of the repaired bit |
| err_bit | output | 3 | Bit position inside that byte |
| host_we | input | 1 | Host write strobe for the sector memory |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the address |

## Verification
The bench builds the unit with its default 512-byte sector and 8-bit data, so the full 9-bit position field of the difference maps onto real memory. This puts both address extremes within reach: byte 0 bit 0, whose difference sits wholly in the low half, and byte 511 bit 7. After repairs and rejected verdicts, the whole sector is swept back through the host port to show that only the intended bit moved. Stray `start` pulses and host writes are placed inside busy windows of both the short and the long (repair) timing to show they have no effect.

// File: rtl/secfix_pkg.sv
package secfix_pkg;

  localparam int CODE_W     = 24;
  localparam int WIDE_W     = 32;
  localparam int POS_W      = 12;
  localparam int BITPOS_W   = 3;
  localparam int BYTEPOS_W  = POS_W - BITPOS_W;
  localparam int POS_LSB    = 16;
  localparam int WEIGHT_W   = $clog2(WIDE_W + 1);
  localparam int SINGLE_WT  = POS_W;
  localparam logic [WIDE_W-1:0] BLANK_WORD = 32'h0FFF_0FFF;

  typedef enum logic [1:0] {
    V_CLEAN = 2'd0,
    V_FIXED = 2'd1,
    V_CODE  = 2'd2,
    V_MULTI = 2'd3
  } verdict_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_EVAL,
    SQ_FETCH,
    SQ_PATCH
  } seq_t;

endpackage

// File: rtl/secfix_unpack.sv
module secfix_unpack
  import secfix_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [WIDE_W-1:0] code_wide
);

  always_comb begin
    code_wide        = '0;
    code_wide[7:0]   = code_in[7:0];
    code_wide[11:8]  = code_in[19:16];
    code_wide[23:16] = code_in[15:8];
    code_wide[27:24] = code_in[23:20];
  end

endmodule

// File: rtl/secfix_classify.sv
module secfix_classify
  import secfix_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [WIDE_W-1:0]    stored_wide,
  input  logic [WIDE_W-1:0]    calc_wide,
  output verdict_t             verdict,
  output logic [BYTEPOS_W-1:0] byte_pos,
  output logic [BITPOS_W-1:0]  bit_pos
);

  localparam int NIBS  = WIDE_W / NIB_W;
  localparam int NCNT_W = $clog2(NIB_W + 1);

  logic [WIDE_W-1:0]   diff;
  logic [NCNT_W-1:0]   nib_cnt [NIBS];
  logic [WEIGHT_W-1:0] weight;

  assign diff = stored_wide ^ calc_wide;

  genvar g;
  generate
    for (g = 0; g < NIBS; g++) begin : g_nib
      always_comb begin
        nib_cnt[g] = '0;
        for (int b = 0; b < NIB_W; b++)
          nib_cnt[g] = nib_cnt[g] + NCNT_W'(diff[g*NIB_W + b]);
      end
    end
  endgenerate

  always_comb begin
    weight = '0;
    for (int n = 0; n < NIBS; n++)
      weight = weight + WEIGHT_W'(nib_cnt[n]);
  end

  always_comb begin
    if (diff == '0)
      verdict = V_CLEAN;
    else if (weight == WEIGHT_W'(SINGLE_WT))
      verdict = V_FIXED;
    else if (weight == WEIGHT_W'(1))
      verdict = V_CODE;
    else if (stored_wide == BLANK_WORD && calc_wide == '0)
      verdict = V_CLEAN;
    else
      verdict = V_MULTI;
  end

  assign bit_pos  = diff[POS_LSB +: BITPOS_W];
  assign byte_pos = diff[POS_LSB + BITPOS_W +: BYTEPOS_W];

endmodule

// File: rtl/secfix_sector_ram.sv
module secfix_sector_ram #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      store[wr_addr] <= wr_data;
    rd_a_data <= store[rd_a_addr];
    rd_b_data <= store[rd_b_addr];
  end

endmodule

// File: rtl/sector_ecc_fixer.sv
module sector_ecc_fixer
  import secfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 8,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CODE_W-1:0]    stored_code,
  input  logic [CODE_W-1:0]    calc_code,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           status,
  output logic [BYTEPOS_W-1:0] err_byte,
  output logic [BITPOS_W-1:0]  err_bit,
  input  logic                 host_we,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata
);

  localparam int NCODES = 2;

  seq_t                 state_q;
  logic [CODE_W-1:0]    code_q [NCODES];
  logic [WIDE_W-1:0]    wide_w [NCODES];
  logic                 busy_q, done_q;
  verdict_t             verdict_w, status_q;
  logic [BYTEPOS_W-1:0] byte_w, byte_q;
  logic [BITPOS_W-1:0]  bit_w, bit_q;

  logic                 fix_we;
  logic                 mem_we;
  logic [ADDR_W-1:0]    mem_waddr, fix_addr;
  logic [DATA_W-1:0]    mem_wdata, fix_rdata, fix_mask;

  genvar c;
  generate
    for (c = 0; c < NCODES; c++) begin : g_unpack
      secfix_unpack u_unpack (
        .code_in   (code_q[c]),
        .code_wide (wide_w[c])
      );
    end
  endgenerate

  secfix_classify u_classify (
    .stored_wide (wide_w[0]),
    .calc_wide   (wide_w[1]),
    .verdict     (verdict_w),
    .byte_pos    (byte_w),
    .bit_pos     (bit_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      status_q  <= V_CLEAN;
      byte_q    <= '0;
      bit_q     <= '0;
      code_q[0] <= '0;
      code_q[1] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            code_q[0] <= stored_code;
            code_q[1] <= calc_code;
            busy_q    <= 1'b1;
            state_q   <= SQ_EVAL;
          end
        end
        SQ_EVAL: begin
          status_q <= verdict_w;
          if (verdict_w == V_FIXED) begin
            byte_q  <= byte_w;
            bit_q   <= bit_w;
            state_q <= SQ_FETCH;
          end else begin
            byte_q  <= '0;
            bit_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= SQ_IDLE;
          end
        end
        SQ_FETCH: state_q <= SQ_PATCH;
        SQ_PATCH: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign fix_addr  = ADDR_W'(byte_q);
  assign fix_mask  = DATA_W'(1) << bit_q;
  assign fix_we    = (state_q == SQ_PATCH);
  assign mem_we    = fix_we | (host_we & (state_q == SQ_IDLE));
  assign mem_waddr = fix_we ? fix_addr : host_addr;
  assign mem_wdata = fix_we ? (fix_rdata ^ fix_mask) : host_wdata;

  secfix_sector_ram #(
    .DEPTH  (SECTOR_BYTES),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk       (clk),
    .wr_en     (mem_we),
    .wr_addr   (mem_waddr),
    .wr_data   (mem_wdata),
    .rd_a_addr (host_addr),
    .rd_a_data (host_rdata),
    .rd_b_addr (fix_addr),
    .rd_b_data (fix_rdata)
  );

  assign busy     = busy_q;
  assign done     = done_q;
  assign status   = status_q;
  assign err_byte = byte_q;
  assign err_bit  = bit_q;

endmodule

// File: rtl/secfix_chk.sv
module secfix_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic [8:0] err_byte,
  input logic [2:0] err_bit,
  input logic       fix_we
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  start_take_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R11
  pos_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status != 2'd1) |-> (err_byte == 9'd0 && err_bit == 3'd0));

  // R3
  patch_done_chk: assert property (@(posedge clk) disable iff (rst)
    fix_we |=> (done && status == 2'd1));

  // R4
  patch_only_fix_chk: assert property (@(posedge clk) disable iff (rst)
    fix_we |-> status == 2'd1);

endmodule

bind sector_ecc_fixer secfix_chk u_secfix_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .status   (status),
  .err_byte (err_byte),
  .err_bit  (err_bit),
  .fix_we   (fix_we)
);

// File: tb/sector_ecc_fixer_tb.sv
module sector_ecc_fixer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;
  logic        host_we = 1'b0;
  logic [8:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] ref_mem [512];
  int m_cnt = 0;
  bit m_busy = 0;
  bit m_done = 0;

  always #2 clk = ~clk;

  sector_ecc_fixer u_dut (
    .clk(clk), .rst(rst), .start(start),
    .stored_code(stored_code), .calc_code(calc_code),
    .busy(busy), .done(done), .status(status),
    .err_byte(err_byte), .err_bit(err_bit),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [31:0] spread(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [23:0] fold(input logic [31:0] d);
    return {d[27:24], d[11:8], d[23:16], d[7:0]};
  endfunction

  function automatic logic [31:0] one_flip(input int b, input int k);
    logic [11:0] p;
    p = {b[8:0], k[2:0]};
    return {4'h0, p, 4'h0, ~p};
  endfunction

  function automatic int judge(input logic [23:0] s, input logic [23:0] c,
                               output int bpos, output int kpos);
    logic [31:0] d;
    int w;
    d = spread(s) ^ spread(c);
    w = $countones(d);
    bpos = 0;
    kpos = 0;
    if (d == 0) return 0;
    if (w == 12) begin
      bpos = int'(d[27:19]);
      kpos = int'(d[18:16]);
      return 1;
    end
    if (w == 1) return 2;
    if (spread(s) == 32'h0FFF0FFF && spread(c) == 0) return 0;
    return 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle model of R7/R8: countdown from the accepting edge.
  always @(posedge clk) begin
    int bp, kp;
    if (rst) begin
      m_cnt  = 0;
      m_busy = 0;
      m_done = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1;
          m_busy = 0;
        end
      end else if (start) begin
        m_busy = 1;
        m_cnt  = (judge(stored_code, calc_code, bp, kp) == 1) ? 3 : 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(busy == m_busy, "R7 busy", busy, m_busy);
      check(done == m_done, "R7 done", done, m_done);
    end
  end

  task automatic host_read(input int a, output logic [7:0] d);
    host_addr = 9'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic sweep(input string req);
    logic [7:0] d;
    int bad = 0;
    int first_a = -1, first_d = 0;
    for (int a = 0; a < 512; a++) begin
      host_read(a, d);
      if (d !== ref_mem[a]) begin
        bad++;
        if (first_a < 0) begin first_a = a; first_d = d; end
      end
    end
    check(bad == 0, req, first_d, (first_a < 0) ? 0 : ref_mem[first_a]);
  endtask

  task automatic run_op(input logic [23:0] s, input logic [23:0] c,
                        input int exp_st, input string req, input bit poke);
    int bp, kp, st;
    st = judge(s, c, bp, kp);
    @(negedge clk);
    stored_code = s;
    calc_code   = c;
    start       = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R8 / R9: stray start and host write inside the busy window
      start       = 1;
      stored_code = c ^ fold(one_flip(7, 2));
      host_we     = 1;
      host_addr   = 9'd5;
      host_wdata  = ~ref_mem[5];
      @(negedge clk);
      start   = 0;
      host_we = 0;
    end
    for (int w = 0; w < 12 && !done; w++) @(negedge clk);
    check(done == 1, {req, " done"}, done, 1);
    check(int'(status) == exp_st, req, status, exp_st);
    check(int'(status) == st, {req, " model"}, status, st);
    check(int'(err_byte) == bp, {req, " byte"}, err_byte, bp);
    check(int'(err_bit) == kp, {req, " bit"}, err_bit, kp);
    if (st == 1) ref_mem[bp] = ref_mem[bp] ^ (8'd1 << kp);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0, "R10 busy", busy, 0);
    check(done == 0, "R10 done", done, 0);
    check(status == 0, "R10 status", status, 0);
    check(err_byte == 0 && err_bit == 0, "R10 pos", err_byte, 0);
    rst = 0;

    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      host_we    = 1;
      host_addr  = 9'(a);
      host_wdata = 8'((a * 7 + 3) & 8'hFF);
      ref_mem[a] = 8'((a * 7 + 3) & 8'hFF);
    end
    @(negedge clk);
    host_we = 0;
    // R9 host read-back
    host_read(77, d);
    check(d == ref_mem[77], "R9 readback", d, ref_mem[77]);

    // R1 equal codes
    run_op(24'h3C5A11, 24'h3C5A11, 0, "R1 clean", 0);
    // R1 R2 layout through a mid-range repair
    run_op(24'h1234AB ^ fold(one_flip(341, 5)), 24'h1234AB, 1, "R2 fix 341.5", 0);
    // R3 lowest position
    run_op(24'h00FF00 ^ fold(one_flip(0, 0)), 24'h00FF00, 1, "R3 fix 0.0", 0);
    // R3 highest position
    run_op(24'hA5A5A5 ^ fold(one_flip(511, 7)), 24'hA5A5A5, 1, "R3 fix 511.7", 0);
    sweep("R3 sector");
    // R4 one flipped code bit (byte1 bit0, then byte2 bit7)
    run_op(24'h555555 ^ 24'h000100, 24'h555555, 2, "R4 code b1", 0);
    run_op(24'h555555 ^ 24'h800000, 24'h555555, 2, "R4 code b2", 0);
    // R5 erased page
    run_op(24'hFFFFFF, 24'h000000, 0, "R5 erased", 0);
    // R6 near-erased and double data error
    run_op(24'hFFFFFF, 24'h000001, 3, "R6 near blank", 0);
    run_op(24'h0F0F0F ^ fold(one_flip(3, 1) ^ one_flip(4, 1)), 24'h0F0F0F, 3, "R6 double", 0);
    sweep("R6 R4 sector kept");
    // R8 R9 disturbances in a long and a short window
    run_op(24'h246801 ^ fold(one_flip(200, 3)), 24'h246801, 1, "R8 repair poke", 1);
    run_op(24'h777777, 24'h777777, 0, "R8 clean poke", 1);
    sweep("R9 busy write dropped");
    // R3 repeat repair restores the byte
    run_op(24'h010203 ^ fold(one_flip(200, 3)), 24'h010203, 1, "R3 re-fix", 0);
    host_read(200, d);
    check(d == 8'((200 * 7 + 3) & 8'hFF), "R3 restored", d, (200 * 7 + 3) & 8'hFF);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule